// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries out the entry into an interrupt handler once an upstream recognizer has accepted an interrupt at an instruction boundary. On a start pulse it takes a private copy of the live status register, the level being serviced and the address of the next instruction. It then rewrites the live status register in two fixed steps. The first step enters supervisor state with tracing off. The second step raises the priority mask to the serviced level. After that it runs an interrupt acknowledge read that carries the level.

The device's answer to that read decides the vector number. The device can supply the vector itself, ask for the level-based autovector, or end the read with a bus error, which marks the interrupt as spurious. The sequencer then issues three stack-write requests: the vector number, the return address and the saved status word. It ends with a one-cycle done pulse that presents the final vector for handler address computation.

Top module: `irq_entry_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle (busy_o low). At acceptance it captures sr_i, level_i and pc_i. Start pulses that arrive while busy_o is high have no effect on the sequence in progress.
- R2: In the first cycle after acceptance, sr_we_o is high and sr_wdata_o equals the captured status word with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared.
- R3: In the next cycle, sr_we_o is high again and sr_wdata_o equals the R2 value with bits 10:8 (priority mask) replaced by the serviced level. Both status writes come before the acknowledge cycle starts.
- R4: The acknowledge cycle drives iack_req_o high, fc_o to 7, and addr_o to all ones except bits 3:1, which carry the level. These outputs hold steady until iack_ack_i is sampled high.
- R5: Response code 0 (vector supplied) takes the vector number from iack_vec_i.
- R6: Response code 1 (autovector) gives vector 24 plus the level, which is 25 to 31 for levels 1 to 7.
- R7: Response code 2 (bus error), and the unused code 3, give the spurious vector 24.
- R8: Three stack-write requests follow, in this order: stk_sel_o 0 with the vector number, stk_sel_o 1 with the return address, and stk_sel_o 2 with the saved status word. Each value is zero-extended on stk_data_o, and each request is held until stk_ack_i is high.
- R9: The pushed status word is the copy taken at acceptance, before either status write. The pushed return address is the pc_i value captured at acceptance.
- R10: After the third stack write is acknowledged, done_o is high for exactly one cycle with vector_o holding the final vector. The block is idle in the following cycle.
- R11: While reset is asserted and after it is released, busy_o, done_o, sr_we_o, iack_req_o and stk_req_o are low, fc_o is 0 and addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accepted interrupt, one-cycle pulse |
| level_i | input | LVL_W | Level of accepted interrupt |
| pc_i | input | PC_W | Address of the next instruction |
| sr_i | input | SR_W | Live status register |
| sr_we_o | output | 1 | Status register write enable |
| sr_wdata_o | output | SR_W | Status register write value |
| iack_req_o | output | 1 | Acknowledge read request |
| fc_o | output | 3 | Function code |
| addr_o | output | ADDR_W | Acknowledge address |
| iack_ack_i | input | 1 | Acknowledge read done |
| iack_resp_i | input | 2 | Response: 0 vector, 1 autovector, 2 bus error |
| iack_vec_i | input | VEC_W | Vector supplied by the device |
| stk_req_o | output | 1 | Stack write request |
| stk_sel_o | output | 2 | Item: 0 vector, 1 return address, 2 status |
| stk_data_o | output | PC_W | Stack write data |
| stk_ack_i | input | 1 | Stack write accepted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| vector_o | output | VEC_W | Final vector number |

## Verification
The bench builds the block with its default parameters: 24 address bits, a 32-bit return address, a 16-bit status word and 8-bit vectors. With these values every level from 1 to 7 can be combined with all four response codes and with two status patterns, one with all bits high and one alternating. This covers every autovector value, both spurious codes and the mask overwrite in both directions. Acknowledge and stack-write delays change from run to run, and extra start pulses are injected while the acknowledge cycle waits, so the hold and ignore rules are exercised under stall.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    RESP_VEC  = 2'd0,
    RESP_AUTO = 2'd1,
    RESP_BERR = 2'd2,
    RESP_RSVD = 2'd3
  } iack_resp_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SUPV, ST_MASK, ST_IACK, ST_PVEC, ST_PPC, ST_PSR, ST_DONE
  } seq_state_e;

  localparam int SR_T1_BIT = 15;
  localparam int SR_T0_BIT = 14;
  localparam int SR_S_BIT  = 13;
  localparam int SR_IPL_LO = 8;
  localparam logic [2:0] FC_IACK = 3'd7;
endpackage

// File: rtl/irq_sr_build.sv
module irq_sr_build #(
  parameter int SR_W  = 16,
  parameter int LVL_W = 3
) (
  input  logic [SR_W-1:0]  sr_copy_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             mask_en_i,
  output logic [SR_W-1:0]  sr_o
);
  import irq_entry_pkg::*;

  logic [SR_W-1:0] supv;

  always_comb begin
    supv = sr_copy_i;
    supv[SR_S_BIT]  = 1'b1;
    supv[SR_T1_BIT] = 1'b0;
    supv[SR_T0_BIT] = 1'b0;
    sr_o = supv;
    if (mask_en_i) sr_o[SR_IPL_LO +: LVL_W] = level_i;
  end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
  parameter int VEC_W    = 8,
  parameter int LVL_W    = 3,
  parameter int SPUR_VEC = 24
) (
  input  logic [1:0]       resp_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] dev_vec_i,
  output logic [VEC_W-1:0] vec_o
);
  import irq_entry_pkg::*;

  localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);

  always_comb begin
    unique case (iack_resp_e'(resp_i))
      RESP_VEC:  vec_o = dev_vec_i;
      RESP_AUTO: vec_o = SPUR + VEC_W'(level_i);
      default:   vec_o = SPUR;
    endcase
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm #(
  parameter int SR_W  = 16,
  parameter int LVL_W = 3,
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [LVL_W-1:0]           level_i,
  input  logic [PC_W-1:0]            pc_i,
  input  logic [SR_W-1:0]            sr_i,
  input  logic                       iack_ack_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  logic                       stk_ack_i,
  output irq_entry_pkg::seq_state_e  state_o,
  output logic [SR_W-1:0]            sr_copy_o,
  output logic [LVL_W-1:0]           level_o,
  output logic [PC_W-1:0]            pc_o,
  output logic [VEC_W-1:0]           vec_o
);
  import irq_entry_pkg::*;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SUPV;
      ST_SUPV: state_d = ST_MASK;
      ST_MASK: state_d = ST_IACK;
      ST_IACK: if (iack_ack_i) state_d = ST_PVEC;
      ST_PVEC: if (stk_ack_i) state_d = ST_PPC;
      ST_PPC:  if (stk_ack_i) state_d = ST_PSR;
      ST_PSR:  if (stk_ack_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sr_copy_o <= '0;
      level_o   <= '0;
      pc_o      <= '0;
      vec_o     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        sr_copy_o <= sr_i;
        level_o   <= level_i;
        pc_o      <= pc_i;
      end
      if (state_q == ST_IACK && iack_ack_i) vec_o <= vec_i;
    end
  end

  assign state_o = state_q;

  // status copy is frozen for the whole sequence
  assert_copy_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_d != ST_IDLE) |=> $stable(sr_copy_o) && $stable(pc_o));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int ADDR_W   = 24,
  parameter int PC_W     = 32,
  parameter int SR_W     = 16,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int SPUR_VEC = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic              sr_we_o,
  output logic [SR_W-1:0]   sr_wdata_o,
  output logic              iack_req_o,
  output logic [2:0]        fc_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              iack_ack_i,
  input  logic [1:0]        iack_resp_i,
  input  logic [VEC_W-1:0]  iack_vec_i,
  output logic              stk_req_o,
  output logic [1:0]        stk_sel_o,
  output logic [PC_W-1:0]   stk_data_o,
  input  logic              stk_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [VEC_W-1:0]  vector_o
);
  import irq_entry_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_ONES = '1;
  localparam int                ADDR_HI_W = ADDR_W - 4;

  seq_state_e       state;
  logic [SR_W-1:0]  sr_copy, sr_next;
  logic [LVL_W-1:0] level_q;
  logic [PC_W-1:0]  pc_q;
  logic [VEC_W-1:0] vec_sel, vec_q;

  irq_entry_fsm #(.SR_W(SR_W), .LVL_W(LVL_W), .PC_W(PC_W), .VEC_W(VEC_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .level_i    (level_i),
    .pc_i       (pc_i),
    .sr_i       (sr_i),
    .iack_ack_i (iack_ack_i),
    .vec_i      (vec_sel),
    .stk_ack_i  (stk_ack_i),
    .state_o    (state),
    .sr_copy_o  (sr_copy),
    .level_o    (level_q),
    .pc_o       (pc_q),
    .vec_o      (vec_q)
  );

  irq_sr_build #(.SR_W(SR_W), .LVL_W(LVL_W)) u_sr_build (
    .sr_copy_i (sr_copy),
    .level_i   (level_q),
    .mask_en_i (state == ST_MASK),
    .sr_o      (sr_next)
  );

  irq_vec_sel #(.VEC_W(VEC_W), .LVL_W(LVL_W), .SPUR_VEC(SPUR_VEC)) u_vec_sel (
    .resp_i    (iack_resp_i),
    .level_i   (level_q),
    .dev_vec_i (iack_vec_i),
    .vec_o     (vec_sel)
  );

  always_comb begin
    sr_we_o    = (state == ST_SUPV) || (state == ST_MASK);
    sr_wdata_o = sr_we_o ? sr_next : '0;
    iack_req_o = (state == ST_IACK);
    fc_o       = iack_req_o ? FC_IACK : 3'd0;
    addr_o     = iack_req_o ? {ADDR_ONES[ADDR_W-1 -: ADDR_HI_W], level_q, 1'b1} : '0;
    stk_req_o  = 1'b0;
    stk_sel_o  = 2'd0;
    stk_data_o = '0;
    unique case (state)
      ST_PVEC: begin stk_req_o = 1'b1; stk_sel_o = 2'd0; stk_data_o = PC_W'(vec_q);   end
      ST_PPC:  begin stk_req_o = 1'b1; stk_sel_o = 2'd1; stk_data_o = pc_q;           end
      ST_PSR:  begin stk_req_o = 1'b1; stk_sel_o = 2'd2; stk_data_o = PC_W'(sr_copy); end
      default: ;
    endcase
    busy_o   = (state != ST_IDLE);
    done_o   = (state == ST_DONE);
    vector_o = vec_q;
  end

  assert_supv_trace_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> sr_wdata_o[SR_S_BIT] && !sr_wdata_o[SR_T1_BIT] && !sr_wdata_o[SR_T0_BIT]);

  assert_sr_before_iack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iack_req_o) |-> $past(sr_we_o));

  assert_iack_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_req_o && !iack_ack_i) |=> iack_req_o && $stable(addr_o) && fc_o == FC_IACK);

  assert_autovec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_req_o && iack_ack_i && iack_resp_i == RESP_AUTO && addr_o[3:1] != 3'd0)
      |=> stk_data_o >= PC_W'(SPUR_VEC + 1) && stk_data_o <= PC_W'(SPUR_VEC + 7));

  assert_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_req_o && iack_ack_i && iack_resp_i[1]) |=> stk_data_o == PC_W'(SPUR_VEC));

  assert_push_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o |-> !iack_req_o && !sr_we_o);

  assert_push_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_req_o && !stk_ack_i) |=> stk_req_o && $stable(stk_sel_o) && $stable(stk_data_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  level = '0;
  logic [31:0] pc = '0;
  logic [15:0] sr_live = '0;
  logic        sr_we;
  logic [15:0] sr_wdata;
  logic        iack_req;
  logic [2:0]  fc;
  logic [23:0] addr;
  logic        iack_ack = 1'b0;
  logic [1:0]  iack_resp = '0;
  logic [7:0]  iack_vec = '0;
  logic        stk_req;
  logic [1:0]  stk_sel;
  logic [31:0] stk_data;
  logic        stk_ack = 1'b0;
  logic        busy, done;
  logic [7:0]  vector;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (sr_we) sr_live <= sr_wdata;

  irq_entry_seq u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .level_i(level), .pc_i(pc),
    .sr_i(sr_live), .sr_we_o(sr_we), .sr_wdata_o(sr_wdata), .iack_req_o(iack_req),
    .fc_o(fc), .addr_o(addr), .iack_ack_i(iack_ack), .iack_resp_i(iack_resp),
    .iack_vec_i(iack_vec), .stk_req_o(stk_req), .stk_sel_o(stk_sel),
    .stk_data_o(stk_data), .stk_ack_i(stk_ack), .busy_o(busy), .done_o(done),
    .vector_o(vector)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push_check(input logic [1:0] sel, input logic [31:0] exp,
                            input int wait_n, input string req);
    chk(stk_req === 1'b1, req, {31'd0, stk_req}, 32'd1);
    chk(stk_sel === sel, req, {30'd0, stk_sel}, {30'd0, sel});
    chk(stk_data === exp, req, stk_data, exp);
    for (int w = 0; w < wait_n; w++) begin
      @(negedge clk);
      chk(stk_req === 1'b1 && stk_data === exp, "R8", stk_data, exp);
    end
    stk_ack = 1'b1;
    @(negedge clk);
    stk_ack = 1'b0;
  endtask

  task automatic run(input logic [2:0] lv, input logic [1:0] resp,
                     input logic [15:0] sr0, input int dly);
    logic [15:0] e_supv, e_mask;
    logic [23:0] e_addr;
    logic [7:0]  dev, e_vec;
    logic [31:0] pcv;
    pcv    = {8'hA5, 5'd0, lv, 8'h3C, 6'd0, resp, resp, lv, 3'd1};
    dev    = {lv, resp, 3'b101};
    e_supv = (sr0 | 16'h2000) & 16'h3FFF;
    e_mask = (e_supv & 16'hF8FF) | ({13'd0, lv} << 8);
    e_addr = 24'hFFFFF1 | ({21'd0, lv} << 1);
    e_vec  = (resp == 2'd0) ? dev : (resp == 2'd1) ? 8'd24 + {5'd0, lv} : 8'd24;

    @(negedge clk);
    sr_live = sr0;
    chk(busy === 1'b0, "R1", {31'd0, busy}, 32'd0);
    start = 1'b1; level = lv; pc = pcv;
    @(negedge clk);
    start = 1'b0; level = ~lv; pc = ~pcv;
    chk(sr_we === 1'b1 && sr_wdata === e_supv, "R2", {15'd0, sr_we, sr_wdata}, {16'd1, e_supv});
    @(negedge clk);
    chk(sr_we === 1'b1 && sr_wdata === e_mask, "R3", {15'd0, sr_we, sr_wdata}, {16'd1, e_mask});
    @(negedge clk);
    chk(sr_live === e_mask, "R3", {16'd0, sr_live}, {16'd0, e_mask});
    chk(iack_req === 1'b1 && fc === 3'd7, "R4", {28'd0, iack_req, fc}, 32'hF);
    chk(addr === e_addr, "R4", {8'd0, addr}, {8'd0, e_addr});
    for (int w = 0; w < dly; w++) begin
      start = 1'b1; level = ~lv;
      @(negedge clk);
      start = 1'b0;
      chk(iack_req === 1'b1 && addr === e_addr, "R1", {8'd0, addr}, {8'd0, e_addr});
    end
    iack_ack = 1'b1; iack_resp = resp; iack_vec = dev;
    @(negedge clk);
    iack_ack = 1'b0; iack_vec = ~dev; iack_resp = ~resp;
    chk(iack_req === 1'b0, "R4", {31'd0, iack_req}, 32'd0);
    case (resp)
      2'd0:    push_check(2'd0, {24'd0, e_vec}, dly, "R5");
      2'd1:    push_check(2'd0, {24'd0, e_vec}, dly, "R6");
      default: push_check(2'd0, {24'd0, e_vec}, dly, "R7");
    endcase
    push_check(2'd1, pcv, 1, "R9");
    push_check(2'd2, {16'd0, sr0}, 0, "R9");
    chk(done === 1'b1 && vector === e_vec, "R10", {23'd0, done, vector}, {23'd1, e_vec});
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", {30'd0, done, busy}, 32'd0);
    chk(sr_live === e_mask, "R8", {16'd0, sr_live}, {16'd0, e_mask});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && sr_we === 1'b0 && iack_req === 1'b0
        && stk_req === 1'b0 && fc === 3'd0 && addr === 24'd0, "R11",
        {23'd0, busy, done, sr_we, iack_req, stk_req, fc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && stk_req === 1'b0, "R11", {30'd0, busy, stk_req}, 32'd0);
    for (int s = 0; s < 2; s++)
      for (int l = 1; l < 8; l++)
        for (int r = 0; r < 4; r++)
          run(3'(l), 2'(r), (s == 0) ? 16'hFFFF : 16'h5A5A, (l + r) % 3);
    summary();
    $finish;
  end
endmodule